// File: doc/BRIEF.md
# Serial 1110010 Pattern Detector

This block watches a one-bit serial stream and flags each complete occurrence of the seven-bit pattern 1110010. It takes one bit on every rising clock edge, first bit of the pattern first. When the last seven bits accepted form the pattern, it raises a single-bit match output. Occurrences may overlap: a bit that ends one pattern can also start the next.

The machine keeps one 3-bit state. The state counts how many leading pattern bits the recent input currently matches. It drives that state on an output port, so that a bench or a neighbouring block can see how far a partial match has got. The match flag is a Moore output, decoded from the state alone. The transition table is computed at elaboration time from the pattern constant. For every partial match and each input bit, it finds the longest prefix of the pattern that is still a suffix of the input.

An active-low reset clears the machine at once. The release of the reset passes through a two-stage synchronizer before the machine starts to follow its input.

Top module: `serial_pattern_fsm`

## Requirements
- R1: `match` is high in a cycle exactly when the last seven bits accepted since the reset was released, oldest first, are 1110010. Overlapping occurrences each produce their own match.
- R2: `match` depends only on `state`. It is high only when `state` equals 7, and it is high whenever `state` equals 7.
- R3: `state` is the number of leading pattern bits matched so far. From code 3, a 1 keeps the machine at 3 and a 0 moves it to 4.
- R4: Fallback on a mismatch: 4 goes to 1 on a 1, 6 goes to 2 on a 1, and 7 goes to 1 on a 1. Codes 0, 1, 2, 5 and 7 go to 0 on a 0.
- R5: While `rst_n` is low, `state` is 0 and `match` is low. Both take these values as soon as `rst_n` falls, with no clock edge needed.
- R6: After `rst_n` rises, the input sampled at the first two rising edges is ignored. The first state update happens at the third rising edge.
- R7: Under random input, all eight state codes, 0 through 7, are reached.
- R8: From codes 0, 1 and 2, a 1 advances the state by one. Codes 4, 5 and 6 advance on 0, 1 and 0 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchronizer |
| din | input | 1 | Serial data bit, sampled at each rising edge |
| match | output | 1 | High while the full pattern has just been received |
| state | output | 3 | Current state: count of pattern bits matched |

## Verification
The situations that are hardest to reach are the overlap fallbacks. These include a 1 arriving in code 6, which must drop to code 2 and not to 0 or 1, and a 1 arriving straight after a full match. Random input reaches code 7 only about once every 128 bits and rarely follows it with the right bit. For this reason a fixed vector walk first chains back-to-back and overlapping partial patterns, so that each fallback edge is taken on purpose. A long random run is then compared every cycle against a shift register of the bits the bench accepted. A directed case pulls the reset low mid-match and checks the outputs before any clock edge.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int unsigned PAT_LEN = 7;
  // Most significant bit is the first bit received.
  localparam logic [PAT_LEN-1:0] PATTERN = 7'b1110010;
  localparam int unsigned STATE_W = $clog2(PAT_LEN + 1);
  localparam int unsigned N_CODES = 2 ** STATE_W;

  typedef logic [STATE_W-1:0] state_t;

  // Pattern bit in arrival order: index 0 is received first.
  function automatic logic pat_bit(input int unsigned idx);
    return PATTERN[PAT_LEN-1-idx];
  endfunction

  // Longest pattern prefix that is a suffix of (matched prefix of length k, then b).
  function automatic state_t next_of(input int unsigned k, input logic b);
    logic [PAT_LEN:0] seq;
    int unsigned      len;
    int unsigned      best;
    logic             ok;
    seq  = '0;
    best = 0;
    if (k > PAT_LEN) begin
      return state_t'(0);
    end
    for (int unsigned i = 0; i < PAT_LEN; i++) begin
      if (i < k) seq[i] = pat_bit(i);
    end
    seq[k] = b;
    len = k + 1;
    for (int unsigned j = 1; j <= PAT_LEN; j++) begin
      if (j <= len) begin
        ok = 1'b1;
        for (int unsigned t = 0; t < PAT_LEN; t++) begin
          if (t < j && seq[len-j+t] != pat_bit(t)) ok = 1'b0;
        end
        if (ok) best = j;
      end
    end
    return state_t'(best);
  endfunction

endpackage

// File: rtl/seqdet_rst_sync.sv
module seqdet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  state_t cur,
  input  logic   bit_in,
  output state_t nxt
);

  state_t on0 [N_CODES];
  state_t on1 [N_CODES];

  for (genvar k = 0; k < N_CODES; k++) begin : g_row
    assign on0[k] = next_of(k, 1'b0);
    assign on1[k] = next_of(k, 1'b1);
  end

  always_comb begin
    if (bit_in) nxt = on1[cur];
    else        nxt = on0[cur];
  end

endmodule

// File: rtl/seqdet_state_reg.sv
module seqdet_state_reg
  import seqdet_pkg::*;
(
  input  logic   clk,
  input  logic   rst_sync_n,
  input  state_t d,
  output state_t q
);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      q <= '0;
    end else begin
      q <= d;
    end
  end

endmodule

// File: rtl/serial_pattern_fsm.sv
module serial_pattern_fsm
  import seqdet_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               din,
  output logic               match,
  output logic [STATE_W-1:0] state
);

  logic   rst_int_n;
  state_t state_q;
  state_t state_d;

  seqdet_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  seqdet_next u_next (
    .cur    (state_q),
    .bit_in (din),
    .nxt    (state_d)
  );

  seqdet_state_reg u_state (
    .clk        (clk),
    .rst_sync_n (rst_int_n),
    .d          (state_d),
    .q          (state_q)
  );

  // Moore decode: full pattern seen.
  always_comb begin
    match = (state_q == state_t'(PAT_LEN));
  end

  assign state = state_q;

endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_int_n,
  input logic       din,
  input logic       match,
  input logic [2:0] state
);

  // R2: a match is only entered from code 6 on a 0
  a_r2_match_entry: assert property (@(posedge clk) disable iff (!rst_int_n)
    match |-> ($past(state) == 3'd6 && !$past(din)));

  // R3: ones hold code 3
  a_r3_hold_ones: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == 3'd3 && din) |=> (state == 3'd3));

  // R4: a zero from codes 0,1,2,5,7 returns to idle
  a_r4_zero_fallback: assert property (@(posedge clk) disable iff (!rst_int_n)
    (din == 1'b0 && (state inside {3'd0, 3'd1, 3'd2, 3'd5, 3'd7})) |=> (state == 3'd0));

  // R4: a one after a full match restarts at code 1
  a_r4_overlap_restart: assert property (@(posedge clk) disable iff (!rst_int_n)
    (match && din) |=> (state == 3'd1));

  // R8: ones advance the early codes by one
  a_r8_advance: assert property (@(posedge clk) disable iff (!rst_int_n)
    (din && state inside {3'd0, 3'd1, 3'd2}) |=> (state == $past(state) + 3'd1));

  // R5: outputs held clear while the reset is applied
  a_r5_reset_clear: assert property (@(posedge clk)
    (!rst_n) |-> (state == 3'd0 && !match));

  // R6: during the synchronizer window the state stays idle
  a_r6_release_idle: assert property (@(posedge clk)
    (!rst_int_n) |-> (state == 3'd0));

endmodule

bind serial_pattern_fsm seqdet_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_int_n (rst_int_n),
  .din       (din),
  .match     (match),
  .state     (state)
);

// File: tb/serial_pattern_fsm_tb_top.sv
module serial_pattern_fsm_tb_top;

  logic       clk;
  logic       rst_n;
  logic       din;
  logic       match;
  logic [2:0] state;

  int unsigned n_checks;
  int unsigned n_errors;
  logic [6:0]  hist;
  logic [7:0]  seen;
  bit          finished;

  localparam logic [6:0] PAT = 7'b1110010;
  localparam int unsigned N_VEC = 25;
  // Each entry: {input bit, expected state after the edge}
  localparam logic [3:0] VEC [N_VEC] = '{
    {1'b1,3'd1},{1'b1,3'd2},{1'b1,3'd3},{1'b0,3'd4},{1'b0,3'd5},
    {1'b1,3'd6},{1'b0,3'd7},{1'b1,3'd1},{1'b1,3'd2},{1'b1,3'd3},
    {1'b1,3'd3},{1'b0,3'd4},{1'b1,3'd1},{1'b1,3'd2},{1'b1,3'd3},
    {1'b0,3'd4},{1'b0,3'd5},{1'b1,3'd6},{1'b1,3'd2},{1'b1,3'd3},
    {1'b0,3'd4},{1'b0,3'd5},{1'b1,3'd6},{1'b0,3'd7},{1'b0,3'd0}
  };

  serial_pattern_fsm dut_i (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (din),
    .match (match),
    .state (state)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Drive a bit, let one edge pass, update the reference history.
  task automatic step(input logic b);
    din = b;
    @(posedge clk);
    #1;
    hist = {hist[5:0], b};
    seen[state] = 1'b1;
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    hist     = '0;
    seen     = '0;
    finished = 1'b0;
    rst_n    = 1'b0;
    din      = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R5 reset state", int'(state), 0);
    check("R5 reset match", int'(match), 0);

    // R6: release with ones on the input
    rst_n = 1'b1;
    din   = 1'b1;
    @(posedge clk); #1;
    check("R6 first edge ignored", int'(state), 0);
    @(posedge clk); #1;
    check("R6 second edge ignored", int'(state), 0);
    @(posedge clk); #1;
    check("R6 third edge updates", int'(state), 1);
    step(1'b0);
    check("R4 code1 on 0", int'(state), 0);
    hist = '0;

    // Vector walk covering advance, hold and overlap fallbacks
    for (int i = 0; i < N_VEC; i++) begin
      step(VEC[i][3]);
      check("R8/R3/R4 table state", int'(state), int'(VEC[i][2:0]));
      check("R1 table match", int'(match), int'(hist == PAT));
    end

    // R5: asynchronous reset during a full match
    for (int i = 6; i >= 0; i--) step(PAT[i]);
    check("R1 match before reset", int'(match), 1);
    rst_n = 1'b0;
    #2;
    check("R5 async state", int'(state), 0);
    check("R5 async match", int'(match), 0);
    din = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R5 idle after release", int'(state), 0);
    hist = '0;

    // Random run against the shift-register reference
    for (int i = 0; i < 4000; i++) begin
      step(1'($urandom_range(0, 1)));
      check("R1 random match", int'(match), int'(hist == PAT));
      check("R2 match is code 7", int'(match), int'(state == 3'd7));
    end
    check("R7 all codes reached", int'(seen), 255);

    finished = 1'b1;
    finish_run();
  end

endmodule